// File: doc/BRIEF.md
# Region-Configured External Bus Controller

This block connects an internal request port to a demultiplexed external bus with a 32-bit data path. The core sends reads and writes of 1, 2 or 4 bytes at any byte address. Requests enter a three-entry queue, so the core can move on while the external bus is busy. A sequencer then takes each request from the queue and issues it as one or more external cycles. Read data comes back to the core in the order the reads were issued.

The top address bits select one of sixteen regions. Static configuration inputs give each region a bus width (8, 16 or 32 bits), a lead wait count, a burst wait count, a byte order and a burst enable. The sequencer splits each access into aligned beats of the region's width. It times every beat from the wait counts, so the bus needs no ready signal. It steers bytes onto the lanes according to the region's byte order. Where the region allows it, consecutive beats run as a burst with a pipelined address. A burst always stops at a 16-byte boundary.

The configuration of the region is taken from the request's start address when the request leaves the queue. That configuration then holds for every beat of the request.

Top module: `region_bus_ctrl`

## Requirements
- R1: The region index is `req_addr[31:28]`. Region k reads its settings from these bit slices: `cfg_width[2k+1:2k]` (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit), `cfg_lead_wait[4k+3:4k]`, `cfg_burst_wait[4k+3:4k]`, `cfg_big_endian[k]` and `cfg_burst_en[k]`.
- R2: An access is split into beats of the region width W bytes. `bus_addr` is aligned to W, byte lane l carries address `bus_addr+l`, and only lanes below W may be enabled. A request of size 4 on an 8-bit region takes 4 data beats, and on a 16-bit region it takes 2.
- R3: Each external cycle starts with one cycle of `bus_ads` high. The first data cycle (`bus_strobe` high) comes lead+1 clocks after the `bus_ads` cycle, and `bus_ads` and `bus_strobe` are never high together.
- R4: In a burst-enabled region the following beats of an access do not repeat `bus_ads`. Each following data cycle comes burst_wait+1 clocks after the one before it. During a data cycle that is followed by a burst beat, `bus_addr` already shows the next beat's address.
- R5: A burst never continues across a 16-byte address boundary. The beat after the boundary starts a new external cycle with its own `bus_ads`.
- R6: In a region without burst enable, every beat has its own `bus_ads`.
- R7: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. In a little-endian region, value byte j (j = 0 is the least significant) is at address start+j. In a big-endian region it is at address start+n-1-j.
- R8: A request at an unaligned address is accepted and carried out as aligned beats that together touch exactly the bytes of the request.
- R9: The queue holds 3 requests, and `req_ready` is low only while it is full. Reads complete in issue order.
- R10: A read gives one cycle of `rsp_valid` after its last data beat, with the value zero-extended in `rsp_rdata`. A write gives no response.
- R11: During reset `req_ready` is 1, and `bus_cyc`, `bus_ads`, `bus_strobe` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered by the core |
| req_ready | output | 1 | Queue can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write value, right-aligned |
| rsp_valid | output | 1 | Read value available |
| rsp_rdata | output | 32 | Read value, zero-extended |
| cfg_width | input | 32 | Per-region width code, 2 bits each |
| cfg_lead_wait | input | 64 | Per-region first-beat wait count, 4 bits each |
| cfg_burst_wait | input | 64 | Per-region burst-beat wait count, 4 bits each |
| cfg_big_endian | input | 16 | Per-region byte order, 1 = big-endian |
| cfg_burst_en | input | 16 | Per-region burst enable |
| bus_cyc | output | 1 | External cycle in progress |
| bus_ads | output | 1 | Address strobe, start of an external cycle |
| bus_strobe | output | 1 | Data transfer cycle |
| bus_we | output | 1 | Write cycle |
| bus_addr | output | 32 | Width-aligned beat address |
| bus_be | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Write data on the lanes |
| bus_rdata | input | 32 | Read data on the lanes |

## Verification
The case hardest to reach from the ports is a burst that has to stop in the middle of an access. This happens when a 4-byte request on a burst-enabled 8-bit region starts two bytes below a 16-byte boundary, so the sequencer must drop out of burst mode and raise a new address strobe. The bench issues that request and counts address strobes and data cycles on the bus. A filled queue is reached by offering five back-to-back reads to a region with a long lead wait. The bench then checks that the ready signal dropped and that the responses came back in issue order.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int WAIT_W = 4;

  typedef struct packed {
    logic              we;
    logic [1:0]        size;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } req_t;

  typedef struct packed {
    logic [1:0]        width;
    logic [WAIT_W-1:0] lead;
    logic [WAIT_W-1:0] bwait;
    logic              big;
    logic              burst;
  } rcfg_t;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_WAIT} seq_state_t;

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rbc_rst_sync.sv
module rbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rbc_req_fifo.sv
module rbc_req_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign rdata = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  // R9: the sequencer never takes an entry from an empty queue
  p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R9: a write into a full queue is never accepted
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full);
endmodule

// File: rtl/rbc_lane_map.sv
module rbc_lane_map
  import rbc_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] start,
  input  logic [2:0]        nbytes,
  input  logic [2:0]        wbytes,
  input  logic              big,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] acc,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lane_wdata,
  output logic [DATA_W-1:0] merged
);
  logic [1:0] vidx [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] off;
    assign off      = base + ADDR_W'(l) - start;
    assign be[l]    = (3'(l) < wbytes) && (off < ADDR_W'(nbytes));
    assign vidx[l]  = big ? 2'(nbytes - 3'd1 - off[2:0]) : off[1:0];
    assign lane_wdata[l*8 +: 8] = be[l] ? wdata[vidx[l]*8 +: 8] : 8'h00;
  end

  always_comb begin
    merged = acc;
    for (int l = 0; l < LANES; l++) begin
      if (be[l]) merged[vidx[l]*8 +: 8] = rdata[l*8 +: 8];
    end
  end
endmodule

// File: rtl/rbc_sequencer.sv
module rbc_sequencer
  import rbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  req_t              head,
  input  rcfg_t             head_cfg,
  output logic              pop,
  output logic              bus_cyc,
  output logic              bus_ads,
  output logic              bus_strobe,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LANES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  seq_state_t        state_q, state_d;
  req_t              cur_q, cur_d;
  rcfg_t             rc_q, rc_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] acc_q, acc_d, rsp_q, rsp_d;
  logic              rspv_q, rspv_d;
  logic              load_en, beat_en;

  logic [2:0]        wb, nb, head_wb;
  logic [ADDR_W:0]   end_a, nxt_a;
  logic              last, cont_burst;
  logic [LANES-1:0]  lane_be;
  logic [DATA_W-1:0] lane_wd, merged;

  assign wb      = width_bytes(rc_q.width);
  assign nb      = size_bytes(cur_q.size);
  assign head_wb = width_bytes(head_cfg.width);
  assign end_a   = {1'b0, cur_q.addr} + (ADDR_W+1)'(nb);
  assign nxt_a   = {1'b0, base_q} + (ADDR_W+1)'(wb);
  assign last    = (nxt_a >= end_a);
  assign cont_burst = rc_q.burst && !last && (nxt_a[3:0] != 4'd0);

  assign bus_cyc    = (state_q != S_IDLE);
  assign bus_ads    = (state_q == S_ADDR);
  assign bus_strobe = (state_q == S_WAIT) && (cnt_q == '0);
  assign bus_we     = bus_cyc && cur_q.we;
  assign bus_addr   = (bus_strobe && cont_burst) ? nxt_a[ADDR_W-1:0] : base_q;
  assign bus_be     = bus_cyc ? lane_be : '0;
  assign bus_wdata  = bus_we ? lane_wd : '0;
  assign rsp_valid  = rspv_q;
  assign rsp_rdata  = rsp_q;

  rbc_lane_map i_lane_map (
    .base       (base_q),
    .start      (cur_q.addr),
    .nbytes     (nb),
    .wbytes     (wb),
    .big        (rc_q.big),
    .wdata      (cur_q.wdata),
    .rdata      (bus_rdata),
    .acc        (acc_q),
    .be         (lane_be),
    .lane_wdata (lane_wd),
    .merged     (merged)
  );

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    rc_d    = rc_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    rsp_d   = rsp_q;
    rspv_d  = 1'b0;
    pop     = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (head_valid) begin
          pop     = 1'b1;
          cur_d   = head;
          rc_d    = head_cfg;
          base_d  = head.addr & ~(ADDR_W'(head_wb) - ADDR_W'(1));
          acc_d   = '0;
          state_d = S_ADDR;
        end
      end
      S_ADDR: begin
        cnt_d   = rc_q.lead;
        state_d = S_WAIT;
      end
      default: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - WAIT_W'(1);
        end else begin
          acc_d  = merged;
          base_d = nxt_a[ADDR_W-1:0];
          if (last) begin
            state_d = S_IDLE;
            rspv_d  = !cur_q.we;
            rsp_d   = merged;
          end else if (cont_burst) begin
            cnt_d = rc_q.bwait;
          end else begin
            state_d = S_ADDR;
          end
        end
      end
    endcase
  end

  assign load_en = pop;
  assign beat_en = pop || bus_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      rspv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rspv_q  <= rspv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      cur_q <= cur_d;
      rc_q  <= rc_d;
    end
    if (beat_en) begin
      base_q <= base_d;
      acc_q  <= acc_d;
    end
    if (rspv_d) rsp_q <= rsp_d;
  end

  // R3: address strobe lasts one cycle and never meets a data cycle
  p_ads_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |=> !bus_ads);
  p_ads_not_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ads && bus_strobe));
  // R2: beat address aligned to the region width, lanes below the width
  p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> ((bus_addr & (ADDR_W'(wb) - ADDR_W'(1))) == '0));
  p_lanes_in_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> ((bus_be >> wb) == '0));
  // R4: a burst beat continues without a fresh address strobe
  p_burst_no_ads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && cont_burst) |=> (bus_cyc && !bus_ads));
  // R5: the pipelined next address never starts a new 16-byte block
  p_burst_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && cont_burst) |-> (bus_addr[3:0] != 4'd0));
  // R10: a response follows a read data cycle
  p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(bus_strobe) && !$past(bus_we)));
endmodule

// File: rtl/region_bus_ctrl.sv
module region_bus_ctrl
  import rbc_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int QDEPTH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [1:0]             req_size,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic [2*NREG-1:0]      cfg_width,
  input  logic [WAIT_W*NREG-1:0] cfg_lead_wait,
  input  logic [WAIT_W*NREG-1:0] cfg_burst_wait,
  input  logic [NREG-1:0]        cfg_big_endian,
  input  logic [NREG-1:0]        cfg_burst_en,
  output logic                   bus_cyc,
  output logic                   bus_ads,
  output logic                   bus_strobe,
  output logic                   bus_we,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [LANES-1:0]       bus_be,
  output logic [DATA_W-1:0]      bus_wdata,
  input  logic [DATA_W-1:0]      bus_rdata
);
  localparam int RSEL_W = $clog2(NREG);

  logic              rst_n_int;
  logic              q_full, q_empty, q_pop, q_push;
  req_t              in_req, head;
  rcfg_t             head_cfg;
  logic [RSEL_W-1:0] rsel;

  rbc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign req_ready = !q_full;
  assign q_push    = req_valid && !q_full;
  assign in_req    = '{we: req_we, size: req_size, addr: req_addr, wdata: req_wdata};

  rbc_req_fifo #(.WIDTH($bits(req_t)), .DEPTH(QDEPTH)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n_int),
    .push  (q_push),
    .wdata (in_req),
    .pop   (q_pop),
    .rdata (head),
    .full  (q_full),
    .empty (q_empty)
  );

  assign rsel           = head.addr[ADDR_W-1 -: RSEL_W];
  assign head_cfg.width = cfg_width[rsel*2 +: 2];
  assign head_cfg.lead  = cfg_lead_wait[rsel*WAIT_W +: WAIT_W];
  assign head_cfg.bwait = cfg_burst_wait[rsel*WAIT_W +: WAIT_W];
  assign head_cfg.big   = cfg_big_endian[rsel];
  assign head_cfg.burst = cfg_burst_en[rsel];

  rbc_sequencer i_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .head_valid (!q_empty),
    .head       (head),
    .head_cfg   (head_cfg),
    .pop        (q_pop),
    .bus_cyc    (bus_cyc),
    .bus_ads    (bus_ads),
    .bus_strobe (bus_strobe),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  // R1/R3: every external cycle is framed by the cycle-active output
  p_cyc_frame_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_ads || bus_strobe) |-> bus_cyc);
endmodule

// File: tb/test_region_bus_ctrl.sv
module test_region_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_we;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] cfg_width;
  logic [63:0] cfg_lead_wait, cfg_burst_wait;
  logic [15:0] cfg_big_endian, cfg_burst_en;
  logic        bus_cyc, bus_ads, bus_strobe, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;

  int checks = 0;
  int errors = 0;
  int ncyc = 0;
  int ads_n = 0, stb_n = 0, rsp_n = 0;
  int ads_t;
  int stb_t [1024];
  logic [31:0] stb_a [1024];
  logic [31:0] rsp_log [1024];
  logic saw_full;
  logic [7:0] mem [4096];
  logic [31:0] cur_a;

  always #5 clk = ~clk;

  region_bus_ctrl i_region_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_width(cfg_width),
    .cfg_lead_wait(cfg_lead_wait), .cfg_burst_wait(cfg_burst_wait),
    .cfg_big_endian(cfg_big_endian), .cfg_burst_en(cfg_burst_en),
    .bus_cyc(bus_cyc), .bus_ads(bus_ads), .bus_strobe(bus_strobe), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic int idx(input logic [31:0] a);
    return int'({a[31:28], a[7:0]});
  endfunction

  // external memory device: latches address on strobe edges
  always @(posedge clk) begin
    if (bus_ads) cur_a <= bus_addr;
    if (bus_strobe) begin
      if (bus_we)
        for (int l = 0; l < 4; l++)
          if (bus_be[l]) mem[idx(cur_a + 32'(l))] <= bus_wdata[l*8 +: 8];
      cur_a <= bus_addr;
    end
  end

  always_comb begin
    for (int l = 0; l < 4; l++) bus_rdata[l*8 +: 8] = mem[idx(cur_a + 32'(l))];
  end

  // observer and watchdog, sampled mid-cycle
  always @(negedge clk) begin
    ncyc++;
    if (bus_ads) begin ads_t = ncyc; ads_n++; end
    if (bus_strobe) begin
      stb_t[stb_n % 1024] = ncyc;
      stb_a[stb_n % 1024] = bus_addr;
      stb_n++;
    end
    if (rsp_valid) begin rsp_log[rsp_n % 1024] = rsp_rdata; rsp_n++; end
    if (ncyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", ncyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_nb(input logic we, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_we = we; req_size = sz; req_addr = a; req_wdata = d;
    while (!req_ready) begin saw_full = 1'b1; @(negedge clk); end
    @(negedge clk);
  endtask

  task automatic push(input logic we, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    push_nb(we, sz, a, d);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    push(1'b1, sz, a, d);
    repeat (60) @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] a, input logic [1:0] sz, output logic [31:0] d);
    int n0 = rsp_n;
    int k = 0;
    push(1'b0, sz, a, 32'h0);
    while (rsp_n == n0 && k < 200) begin @(negedge clk); k++; end
    d = (rsp_n == n0) ? 32'hxxxxxxxx : rsp_log[n0 % 1024];
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] mem32(input logic [31:0] a);
    return {mem[idx(a+3)], mem[idx(a+2)], mem[idx(a+1)], mem[idx(a)]};
  endfunction

  task automatic t_reset;
    chk("R11 req_ready in reset", 32'(req_ready), 32'd1);
    chk("R11 bus_cyc in reset", 32'(bus_cyc), 32'd0);
    chk("R11 strobes in reset", 32'({bus_ads, bus_strobe}), 32'd0);
    chk("R11 rsp_valid in reset", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_aligned;
    int a0 = ads_n, s0 = stb_n, r0 = rsp_n;
    logic [31:0] d;
    wr(32'h1000_0010, 2'd2, 32'hDEAD_BEEF);
    chk("R1 region1 one ads", 32'(ads_n - a0), 32'd1);
    chk("R2 32-bit one beat", 32'(stb_n - s0), 32'd1);
    chk("R3 lead 3 -> strobe 4 after ads", 32'(stb_t[s0 % 1024] - ads_t), 32'd4);
    chk("R7 LE memory image", mem32(32'h1000_0010), 32'hDEAD_BEEF);
    chk("R10 write gives no response", 32'(rsp_n - r0), 32'd0);
    rd(32'h1000_0010, 2'd2, d);
    chk("R10 read back aligned", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_burst;
    int a0 = ads_n, s0 = stb_n;
    logic [31:0] d;
    wr(32'h2000_0020, 2'd2, 32'h4433_2211);
    chk("R2 8-bit region four beats", 32'(stb_n - s0), 32'd4);
    chk("R4 burst single ads", 32'(ads_n - a0), 32'd1);
    chk("R3 lead 2 -> strobe 3 after ads", 32'(stb_t[s0 % 1024] - ads_t), 32'd3);
    chk("R4 burst beat gap", 32'(stb_t[(s0+2) % 1024] - stb_t[(s0+1) % 1024]), 32'd2);
    chk("R4 pipelined next address", stb_a[s0 % 1024], 32'h2000_0021);
    chk("R2 byte lanes in memory", mem32(32'h2000_0020), 32'h4433_2211);
    rd(32'h2000_0020, 2'd2, d);
    chk("R2 8-bit read assembled", d, 32'h4433_2211);
  endtask

  task automatic t_nonburst;
    int a0 = ads_n, s0 = stb_n;
    logic [31:0] d;
    wr(32'h3000_0040, 2'd2, 32'hCAFE_F00D);
    chk("R6 16-bit no burst two ads", 32'(ads_n - a0), 32'd2);
    chk("R2 16-bit two beats", 32'(stb_n - s0), 32'd2);
    rd(32'h3000_0040, 2'd2, d);
    chk("R2 16-bit read back", d, 32'hCAFE_F00D);
  endtask

  task automatic t_big;
    int a0, s0;
    logic [31:0] d;
    wr(32'h4000_0008, 2'd2, 32'h1122_3344);
    chk("R7 BE image", mem32(32'h4000_0008), 32'h4433_2211);
    rd(32'h4000_0008, 2'd2, d);
    chk("R7 BE read back", d, 32'h1122_3344);
    rd(32'h4000_000A, 2'd1, d);
    chk("R7 BE halfword", d, 32'h0000_3344);
    a0 = ads_n; s0 = stb_n;
    wr(32'h5000_0003, 2'd1, 32'h0000_A1B2);
    chk("R7 BE 8-bit low address", 32'(mem[idx(32'h5000_0003)]), 32'hA1);
    chk("R7 BE 8-bit high address", 32'(mem[idx(32'h5000_0004)]), 32'hB2);
    chk("R4 unaligned burst one ads", 32'(ads_n - a0), 32'd1);
    chk("R4 zero burst wait gap", 32'(stb_t[(s0+1) % 1024] - stb_t[s0 % 1024]), 32'd1);
  endtask

  task automatic t_unaligned;
    int a0 = ads_n, s0 = stb_n;
    logic [31:0] d;
    mem[idx(32'h0000_0030)] = 8'h5A;
    mem[idx(32'h0000_0035)] = 8'hA5;
    wr(32'h0000_0031, 2'd2, 32'h8899_AABB);
    chk("R8 unaligned two beats", 32'(stb_n - s0), 32'd2);
    chk("R8 unaligned two ads", 32'(ads_n - a0), 32'd2);
    chk("R8 bytes landed", mem32(32'h0000_0031), 32'h8899_AABB);
    chk("R8 neighbours untouched", {mem[idx(32'h0000_0035)], mem[idx(32'h0000_0030)]}, 32'h0000_A55A);
    rd(32'h0000_0031, 2'd2, d);
    chk("R8 unaligned read", d, 32'h8899_AABB);
    rd(32'h0000_0031, 2'd0, d);
    chk("R10 byte zero-extended", d, 32'h0000_00BB);
    rd(32'h0000_0032, 2'd1, d);
    chk("R10 halfword zero-extended", d, 32'h0000_99AA);
  endtask

  task automatic t_boundary;
    int a0 = ads_n, s0 = stb_n;
    wr(32'h2000_004E, 2'd2, 32'h0D0C_0B0A);
    chk("R5 boundary splits burst", 32'(ads_n - a0), 32'd2);
    chk("R5 four beats total", 32'(stb_n - s0), 32'd4);
    chk("R5 data across boundary", mem32(32'h2000_004E), 32'h0D0C_0B0A);
  endtask

  task automatic t_queue;
    int n0 = rsp_n;
    int k = 0;
    logic [31:0] exp [5];
    exp[0] = 32'hDEAD_BEEF; exp[1] = 32'hCAFE_F00D; exp[2] = 32'h1122_3344;
    exp[3] = 32'h4433_2211; exp[4] = 32'hDEAD_BEEF;
    saw_full = 1'b0;
    push_nb(1'b0, 2'd2, 32'h1000_0010, 32'h0);
    push_nb(1'b0, 2'd2, 32'h3000_0040, 32'h0);
    push_nb(1'b0, 2'd2, 32'h4000_0008, 32'h0);
    push_nb(1'b0, 2'd2, 32'h2000_0020, 32'h0);
    push_nb(1'b0, 2'd2, 32'h1000_0010, 32'h0);
    req_valid = 1'b0;
    while (rsp_n - n0 < 5 && k < 500) begin @(negedge clk); k++; end
    chk("R9 ready dropped when full", 32'(saw_full), 32'd1);
    chk("R9 all reads answered", 32'(rsp_n - n0), 32'd5);
    for (int i = 0; i < 5; i++) chk("R9 read order", rsp_log[(n0+i) % 1024], exp[i]);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    cur_a = 32'h0;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_size = 2'd0;
    req_addr = 32'h0; req_wdata = 32'h0; saw_full = 1'b0;
    cfg_width = {16{2'd2}}; cfg_lead_wait = '0; cfg_burst_wait = '0;
    cfg_big_endian = '0; cfg_burst_en = '0;
    cfg_lead_wait[1*4 +: 4] = 4'd3;
    cfg_width[2*2 +: 2] = 2'd0; cfg_lead_wait[2*4 +: 4] = 4'd2;
    cfg_burst_wait[2*4 +: 4] = 4'd1; cfg_burst_en[2] = 1'b1;
    cfg_width[3*2 +: 2] = 2'd1; cfg_lead_wait[3*4 +: 4] = 4'd1;
    cfg_lead_wait[4*4 +: 4] = 4'd1; cfg_big_endian[4] = 1'b1;
    cfg_width[5*2 +: 2] = 2'd0; cfg_lead_wait[5*4 +: 4] = 4'd1;
    cfg_big_endian[5] = 1'b1; cfg_burst_en[5] = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_aligned;
    t_burst;
    t_nonburst;
    t_big;
    t_unaligned;
    t_boundary;
    t_queue;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule